// File: doc/BRIEF.md
# USB Host Root Port Control

This block holds the per-port control and status bits of a USB host root port that software reads and writes through a port register. Each write strobe carries three bits: the bus-reset request, the suspend request and the force-resume request. The block turns these into the bits that software reads back and into control levels for the line signalling layer. None of the bits is plain storage. A reset request starts a timed bus reset. The reset bit goes on reading 1 after software releases it, until the reset has ended. The port enables itself if a high-speed device was seen during the reset. Suspend takes effect only at a transaction boundary, and software cannot clear it directly.

The bus reset runs on a microsecond tick. It is held for at least `MIN_HOLD_US` ticks, counted from its start. Once software has released the reset bit and that minimum has passed, a termination phase of `TERM_US` ticks follows. `TERM_US` stays well under 2 ms. When the controller is halted, reset writes are ignored and a running reset does not finish.

Top module: `hport_ctl`

## Requirements
- R1: A write with the reset bit at 1, while the controller is not halted and no reset is running, sets `rd_reset` and `drv_bus_reset` from the next cycle. The drive continues while software holds the bit at 1.
- R2: The start of a reset clears `rd_enabled` in the same cycle that `rd_reset` rises.
- R3: After software writes 0 to the reset bit, `rd_reset` keeps reading 1. It falls exactly `MIN_HOLD_US + TERM_US` ticks after the reset started, provided the release came before `MIN_HOLD_US` ticks had elapsed.
- R4: When a reset ends, `rd_enabled` becomes 1 if `hs_detect` was high in any cycle of the drive phase, and stays 0 otherwise.
- R5: `port_state` is decoded as follows: 0 = disabled (enabled bit 0, whatever the suspend bit holds), 1 = enabled (enabled 1, suspend 0), 2 = suspended (enabled 1, suspend 1).
- R6: A write of suspend = 1 to an enabled port while `xfer_busy` is 1 leaves `rd_suspend` and `drv_block` at 0. They become 1 in the cycle after the first clock edge at which `xfer_busy` is 0. A write made while `xfer_busy` is 0 sets them from the next cycle.
- R7: A write of suspend = 0 never clears `rd_suspend`.
- R8: A write that changes force-resume from 1 to 0 clears `rd_suspend` and cancels any pending suspend. `drv_resume` follows the force-resume bit last written.
- R9: The start of a reset clears `rd_suspend`. The bus reset is driven even when the port was suspended.
- R10: While `ctrl_halted` is 1, the reset bit of every write is ignored, and a running reset keeps `rd_reset` at 1.
- R11: A write of suspend = 1 while `rd_enabled` is 0 leaves `rd_suspend` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write strobe, one cycle |
| wr_reset_bit | input | 1 | Written value of the reset request |
| wr_susp_bit | input | 1 | Written value of the suspend request |
| wr_fres_bit | input | 1 | Written value of the force-resume request |
| ctrl_halted | input | 1 | Host controller halted |
| xfer_busy | input | 1 | A bus transaction is in progress |
| hs_detect | input | 1 | Attached device signalled high speed |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| rd_reset | output | 1 | Reset bit as read by software |
| rd_enabled | output | 1 | Port-enabled bit |
| rd_suspend | output | 1 | Suspend bit |
| rd_fres | output | 1 | Force-resume bit |
| port_state | output | 2 | Decoded port state (R5 encoding) |
| drv_bus_reset | output | 1 | Drive bus reset signalling |
| drv_block | output | 1 | Block downstream traffic |
| drv_resume | output | 1 | Drive resume signalling |

## Verification
The assertions assume that `us_tick` is a single-cycle pulse and never sits high on two consecutive cycles. They also assume that `wr_valid` lasts one cycle per write, and that `xfer_busy` and `hs_detect` are synchronous levels that change only between clock edges. The bench produces the tick from a divide-by-four counter. It drives every input on the falling edge and issues writes through one task that raises `wr_valid` for exactly one cycle. It shortens the reset windows by parameter, so each reset takes a few dozen cycles and its tick count can be checked exactly.

// File: rtl/hport_pkg.sv
package hport_pkg;

  typedef enum logic [1:0] {
    PS_DISABLED  = 2'd0,
    PS_ENABLED   = 2'd1,
    PS_SUSPENDED = 2'd2
  } port_state_e;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_DRIVE = 2'd1,
    RS_TERM  = 2'd2
  } rst_phase_e;

  function automatic port_state_e decode_state(input logic en, input logic susp);
    if (!en)      return PS_DISABLED;
    else if (susp) return PS_SUSPENDED;
    else           return PS_ENABLED;
  endfunction

  // saturating increment used by the hold counter
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

endpackage

// File: rtl/hport_rst_seq.sv
module hport_rst_seq
  import hport_pkg::*;
#(
  parameter int MIN_HOLD_US = 50000,
  parameter int TERM_US     = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic halted,
  input  logic start,
  input  logic rearm,
  input  logic release_req,
  input  logic hs_detect,
  output logic active,
  output logic driving,
  output logic done,
  output logic hs_seen
);

  localparam int CMAX = (MIN_HOLD_US > TERM_US) ? MIN_HOLD_US : TERM_US;
  localparam int CW   = $clog2(CMAX + 1);

  rst_phase_e    phase;
  logic [CW-1:0] cnt;
  logic          held;
  logic          hold_met;
  logic          term_last;

  assign hold_met  = (32'(cnt) >= 32'(MIN_HOLD_US));
  assign term_last = (32'(cnt) == 32'(TERM_US - 1));
  assign done      = (phase == RS_TERM) && us_tick && !halted && term_last;
  assign active    = (phase != RS_IDLE);
  assign driving   = (phase == RS_DRIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= RS_IDLE;
      cnt     <= '0;
      held    <= 1'b0;
      hs_seen <= 1'b0;
    end else begin
      case (phase)
        RS_IDLE: begin
          if (start) begin
            phase   <= RS_DRIVE;
            cnt     <= '0;
            held    <= 1'b1;
            hs_seen <= 1'b0;
          end
        end
        RS_DRIVE: begin
          if (us_tick)
            cnt <= CW'(sat_inc(32'(cnt), 32'(MIN_HOLD_US)));
          if (hs_detect)
            hs_seen <= 1'b1;
          if (release_req)
            held <= 1'b0;
          else if (rearm)
            held <= 1'b1;
          if (!held && hold_met && !halted) begin
            phase <= RS_TERM;
            cnt   <= '0;
          end
        end
        RS_TERM: begin
          if (us_tick && !halted) begin
            if (term_last) begin
              phase <= RS_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        default: phase <= RS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hport_susp.sv
module hport_susp (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic busy,
  output logic susp,
  output logic pending,
  output logic set_ev
);

  logic want;

  assign want   = set_req || pending;
  assign set_ev = want && !busy && !clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp    <= 1'b0;
      pending <= 1'b0;
    end else if (clr_req) begin
      susp    <= 1'b0;
      pending <= 1'b0;
    end else if (set_ev) begin
      susp    <= 1'b1;
      pending <= 1'b0;
    end else if (want) begin
      pending <= 1'b1;
    end
  end

endmodule

// File: rtl/hport_ctl.sv
module hport_ctl
  import hport_pkg::*;
#(
  parameter int MIN_HOLD_US = 50000,
  parameter int TERM_US     = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       wr_reset_bit,
  input  logic       wr_susp_bit,
  input  logic       wr_fres_bit,
  input  logic       ctrl_halted,
  input  logic       xfer_busy,
  input  logic       hs_detect,
  input  logic       us_tick,
  output logic       rd_reset,
  output logic       rd_enabled,
  output logic       rd_suspend,
  output logic       rd_fres,
  output logic [1:0] port_state,
  output logic       drv_bus_reset,
  output logic       drv_block,
  output logic       drv_resume
);

  logic rst_wr_ok;
  logic rst_start;
  logic rst_rearm;
  logic rst_release;
  logic rst_active;
  logic rst_driving;
  logic rst_done;
  logic hs_seen;
  logic fres_q;
  logic fres_fall;
  logic susp_clr_ev;
  logic susp_set_req;
  logic susp_set_ev;
  logic susp_pending;
  logic susp_q;
  logic en_q;

  assign rst_wr_ok   = wr_valid && !ctrl_halted;
  assign rst_start   = rst_wr_ok && wr_reset_bit && !rst_active;
  assign rst_rearm   = rst_wr_ok && wr_reset_bit;
  assign rst_release = rst_wr_ok && !wr_reset_bit;

  assign fres_fall    = wr_valid && !wr_fres_bit && fres_q;
  assign susp_clr_ev  = fres_fall || rst_start;
  assign susp_set_req = wr_valid && wr_susp_bit && en_q && !rst_active;

  hport_rst_seq #(
    .MIN_HOLD_US(MIN_HOLD_US),
    .TERM_US    (TERM_US)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .us_tick    (us_tick),
    .halted     (ctrl_halted),
    .start      (rst_start),
    .rearm      (rst_rearm),
    .release_req(rst_release),
    .hs_detect  (hs_detect),
    .active     (rst_active),
    .driving    (rst_driving),
    .done       (rst_done),
    .hs_seen    (hs_seen)
  );

  hport_susp u_susp (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(susp_set_req),
    .clr_req(susp_clr_ev),
    .busy   (xfer_busy),
    .susp   (susp_q),
    .pending(susp_pending),
    .set_ev (susp_set_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      fres_q <= 1'b0;
    end else begin
      if (rst_start)
        en_q <= 1'b0;
      else if (rst_done)
        en_q <= hs_seen;
      if (wr_valid)
        fres_q <= wr_fres_bit;
    end
  end

  assign rd_reset      = rst_active;
  assign rd_enabled    = en_q;
  assign rd_suspend    = susp_q;
  assign rd_fres       = fres_q;
  assign port_state    = decode_state(en_q, susp_q);
  assign drv_bus_reset = rst_driving;
  assign drv_block     = susp_q;
  assign drv_resume    = fres_q;

endmodule

// File: rtl/hport_ctl_chk.sv
module hport_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic ctrl_halted,
  input logic xfer_busy,
  input logic rst_start,
  input logic rst_done,
  input logic susp_clr_ev,
  input logic rd_reset,
  input logic rd_enabled,
  input logic rd_suspend,
  input logic drv_bus_reset,
  input logic drv_block
);

  // R1
  a_r1_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |=> (rd_reset && drv_bus_reset));

  // R2 and R9
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |=> (!rd_enabled && !rd_suspend));

  // R4
  a_r4_enable_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_enabled) |-> $past(rst_done));

  // R6
  a_r6_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_suspend) |-> !$past(xfer_busy));

  // R7 and R8
  a_r7_no_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_suspend) |-> $past(susp_clr_ev));

  // R10
  a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_halted && rd_reset) |=> rd_reset);

  // R11
  a_r11_block_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    drv_block |-> rd_enabled);

endmodule

bind hport_ctl hport_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_halted  (ctrl_halted),
  .xfer_busy    (xfer_busy),
  .rst_start    (rst_start),
  .rst_done     (rst_done),
  .susp_clr_ev  (susp_clr_ev),
  .rd_reset     (rd_reset),
  .rd_enabled   (rd_enabled),
  .rd_suspend   (rd_suspend),
  .drv_bus_reset(drv_bus_reset),
  .drv_block    (drv_block)
);

// File: tb/hport_ctl_test.sv
`timescale 1ns/1ps
module hport_ctl_test;

  localparam int MIN_T  = 8;
  localparam int TERM_T = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_reset_bit = 1'b0, wr_susp_bit = 1'b0, wr_fres_bit = 1'b0;
  logic ctrl_halted = 1'b0, xfer_busy = 1'b0, hs_detect = 1'b0, us_tick = 1'b0;
  logic rd_reset, rd_enabled, rd_suspend, rd_fres, drv_bus_reset, drv_block, drv_resume;
  logic [1:0] port_state;

  int errors = 0;
  int checks = 0;
  int tick_total = 0;
  int cycles = 0;
  logic [1:0] div = 2'd0;

  hport_ctl #(.MIN_HOLD_US(MIN_T), .TERM_US(TERM_T)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_reset_bit(wr_reset_bit),
    .wr_susp_bit(wr_susp_bit), .wr_fres_bit(wr_fres_bit), .ctrl_halted(ctrl_halted),
    .xfer_busy(xfer_busy), .hs_detect(hs_detect), .us_tick(us_tick),
    .rd_reset(rd_reset), .rd_enabled(rd_enabled), .rd_suspend(rd_suspend),
    .rd_fres(rd_fres), .port_state(port_state), .drv_bus_reset(drv_bus_reset),
    .drv_block(drv_block), .drv_resume(drv_resume)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    div     <= div + 2'd1;
    us_tick <= (div == 2'd3);
  end

  always @(posedge clk) begin
    if (us_tick) tick_total <= tick_total + 1;
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic r, input logic s, input logic f);
    @(negedge clk);
    wr_valid = 1'b1; wr_reset_bit = r; wr_susp_bit = s; wr_fres_bit = f;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_reset_end();
    for (int i = 0; i < 400; i++) begin
      if (!rd_reset) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    chk("R1 reset rd_reset", rd_reset, 0);
    chk("R4 reset rd_enabled", rd_enabled, 0);
    chk("R6 reset rd_suspend", rd_suspend, 0);
    chk("R5 reset port_state", port_state, 0);
  endtask

  task automatic t_hs_reset();
    int t0;
    hs_detect = 1'b1;
    wr(1'b1, 1'b0, 1'b0);
    t0 = tick_total;
    chk("R1 rd_reset after set", rd_reset, 1);
    chk("R1 drv_bus_reset", drv_bus_reset, 1);
    chk("R2 enabled cleared", rd_enabled, 0);
    wait_cycles(3);
    chk("R1 drive held", drv_bus_reset, 1);
    wr(1'b0, 1'b0, 1'b0);
    chk("R3 readback after release", rd_reset, 1);
    wait_reset_end();
    chk("R3 tick count", tick_total - t0, MIN_T + TERM_T);
    chk("R3 reset ended", rd_reset, 0);
    chk("R4 hs auto-enable", rd_enabled, 1);
    chk("R5 state enabled", port_state, 1);
    hs_detect = 1'b0;
  endtask

  task automatic t_susp_busy();
    xfer_busy = 1'b1;
    wr(1'b0, 1'b1, 1'b0);
    chk("R6 not yet suspended", rd_suspend, 0);
    wait_cycles(3);
    chk("R6 block waits", drv_block, 0);
    xfer_busy = 1'b0;
    @(negedge clk);
    chk("R6 suspended at boundary", rd_suspend, 1);
    chk("R6 block", drv_block, 1);
    chk("R5 state suspended", port_state, 2);
  endtask

  task automatic t_sw_clear();
    wr(1'b0, 1'b0, 1'b0);
    chk("R7 write 0 ignored", rd_suspend, 1);
  endtask

  task automatic t_fres();
    wr(1'b0, 1'b1, 1'b1);
    chk("R8 drv_resume", drv_resume, 1);
    chk("R8 still suspended", rd_suspend, 1);
    wr(1'b0, 1'b0, 1'b0);
    chk("R8 fres fall clears", rd_suspend, 0);
    chk("R8 drv_resume off", drv_resume, 0);
    chk("R5 back to enabled", port_state, 1);
  endtask

  task automatic t_reset_from_susp();
    wr(1'b0, 1'b1, 1'b0);
    chk("R6 idle bus suspend", rd_suspend, 1);
    wr(1'b1, 1'b0, 1'b0);
    chk("R9 suspend cleared", rd_suspend, 0);
    chk("R9 bus reset driven", drv_bus_reset, 1);
    chk("R2 enabled cleared", rd_enabled, 0);
    chk("R5 state disabled", port_state, 0);
    wr(1'b0, 1'b0, 1'b0);
    wait_reset_end();
    chk("R4 full speed stays disabled", rd_enabled, 0);
    wr(1'b0, 1'b1, 1'b0);
    chk("R11 suspend while disabled", rd_suspend, 0);
  endtask

  task automatic t_halt();
    ctrl_halted = 1'b1;
    wr(1'b1, 1'b0, 1'b0);
    chk("R10 set ignored when halted", rd_reset, 0);
    ctrl_halted = 1'b0;
    wr(1'b1, 1'b0, 1'b0);
    chk("R10 start when running", rd_reset, 1);
    ctrl_halted = 1'b1;
    wr(1'b0, 1'b0, 1'b0);
    wait_cycles(80);
    chk("R10 reset held while halted", rd_reset, 1);
    ctrl_halted = 1'b0;
    wr(1'b0, 1'b0, 1'b0);
    wait_reset_end();
    chk("R10 finishes after unhalt", rd_reset, 0);
  endtask

  initial begin
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(2);
    t_reset_state();
    t_hs_reset();
    t_susp_busy();
    t_sw_clear();
    t_fres();
    t_reset_from_susp();
    t_halt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule